// File: doc/BRIEF.md
# Flash Power-Up Write-Inhibit Controller

This block sequences a serial NOR flash out of power-on and decides which decoded instructions may act. It takes two digitized supply flags. The first says the rail is above the write-inhibit threshold. The second says the rail is at or above the minimum operating level. While the first flag is low, the controller holds the core in reset, and every instruction strobe from the SPI front end is refused.

Two saturating cycle counters measure the power-up delays. A long write delay starts when the rail crosses the inhibit threshold. A shorter select delay starts when the rail reaches its operating level. Reads are permitted once the select delay has run out. Write-class instructions also need the write delay to have run out. For each strobe the block returns an accept or ignore decision in the same cycle.

The block also holds three status bits: the write-enable latch, the write-in-progress flag and a deep power-down state. An ignored instruction changes none of them.

Top module: `flash_pwrup_guard`

## Requirements
- R1: While `above_wi` is low, `core_rst` is high, `read_ok` and `write_ok` are low, and every strobe gives `instr_ignore`=1 and `instr_accept`=0 in the same cycle.
- R2: The write-class opcodes are 0x06 (enable write), 0x02 (program page), 0xD8 (erase sector), 0xC7 (erase all) and 0x01 (write status). They are ignored until `above_wi` has been sampled high on WR_DELAY rising edges. After that the write counter stays saturated for as long as `above_wi` stays high.
- R3: `read_ok` rises once `above_wi` and `above_min` have both been sampled high on SEL_DELAY edges. From then on, the read opcodes 0x03 and 0x0B and all other non-write opcodes are accepted, even while the write delay is still running.
- R4: `write_ok` is high only when both delays have run out, whichever of them finishes last.
- R5: An ignored strobe raises `instr_ignore` for exactly the cycle of the strobe. It leaves `wel`, `wip` and `deep_pd` unchanged.
- R6: After reset, `wel`, `wip` and `deep_pd` are all 0, so the device starts in standby.
- R7: A fall of `above_wi` at any time disables everything in the same cycle. Both counters then restart from zero on the next rise.
- R8: A fall of `above_min` while `above_wi` stays high drops `read_ok` and `write_ok` in the same cycle. The select delay must then run out again before they return.
- R9: An accepted 0x06 sets `wel` on the clock edge where it is sampled.
- R10: An accepted 0x02, 0xD8, 0xC7 or 0x01 with `wel`=1 and `wip`=0 clears `wel` and holds `wip` high for BUSY_CYCLES cycles. The same opcode accepted with `wel`=0 changes nothing.
- R11: An accepted 0xB9 sets `deep_pd`. While `deep_pd` is set, only 0xAB is accepted, and it clears `deep_pd`. Every other opcode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| above_wi | input | 1 | Rail above write-inhibit threshold |
| above_min | input | 1 | Rail at or above minimum operating level |
| instr_valid | input | 1 | One-cycle decoded instruction strobe |
| instr_code | input | 8 | Decoded opcode |
| core_rst | output | 1 | Internal reset to the flash core |
| read_ok | output | 1 | Read-class instructions permitted |
| write_ok | output | 1 | Write-class instructions permitted |
| instr_accept | output | 1 | Current strobe is executed |
| instr_ignore | output | 1 | Current strobe is dropped |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write-in-progress status |
| deep_pd | output | 1 | Deep power-down state |

## Verification
The bench places its probes one edge before and on the exact edge where each counter reaches its limit. An off-by-one counter would open reads or writes a cycle early or late. The bench raises `above_min` long after `above_wi`, which shows whether `write_ok` waits for the later of the two delays rather than the first one to finish. It also drops each supply flag separately, to catch counters that do not restart or permits that linger for a registered cycle. Finally, it sends an enable-write strobe while the write path is inhibited and again during deep power-down: a design that lets an ignored strobe touch state would set `wel`.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_PP    = 8'h02;
  localparam logic [7:0] OP_SE    = 8'hD8;
  localparam logic [7:0] OP_BE    = 8'hC7;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_DPD   = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  typedef enum logic [1:0] {
    CLS_READ  = 2'd0,
    CLS_WRITE = 2'd1,
    CLS_OTHER = 2'd2
  } cmd_class_e;

  // Class of an opcode for power-up gating.
  function automatic cmd_class_e classify(input logic [7:0] code);
    case (code)
      OP_WREN, OP_PP, OP_SE, OP_BE, OP_WRSR: classify = CLS_WRITE;
      OP_READ, OP_FREAD:                     classify = CLS_READ;
      default:                               classify = CLS_OTHER;
    endcase
  endfunction

  // Opcodes that start a busy cycle when the latch is set.
  function automatic logic is_modify(input logic [7:0] code);
    is_modify = (code == OP_PP) || (code == OP_SE) ||
                (code == OP_BE) || (code == OP_WRSR);
  endfunction

endpackage

// File: rtl/power_delay_timer.sv
module power_delay_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic clear,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TERM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clear)            cnt <= '0;
    else if (cnt != TERM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == TERM);

  // R2: once expired, the timer stays expired until cleared
  a_r2_done_sticky: assert property (@(posedge clk) disable iff (clear)
    done |=> done);

endmodule

// File: rtl/flash_status_regs.sv
module flash_status_regs #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic set_wel,
  input  logic start_busy,
  input  logic enter_dp,
  input  logic leave_dp,
  output logic wel,
  output logic wip,
  output logic dpd
);
  localparam int BW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [BW-1:0] LAST = BW'(BUSY_CYCLES - 1);

  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel      <= 1'b0;
      wip      <= 1'b0;
      dpd      <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (start_busy) begin
        wip      <= 1'b1;
        wel      <= 1'b0;
        busy_cnt <= '0;
      end else begin
        if (set_wel) wel <= 1'b1;
        if (wip) begin
          if (busy_cnt == LAST) wip <= 1'b0;
          else                  busy_cnt <= busy_cnt + 1'b1;
        end
      end
      if (enter_dp)      dpd <= 1'b1;
      else if (leave_dp) dpd <= 1'b0;
    end
  end

  // R6: reset leaves every status bit cleared
  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> (!wel && !wip && !dpd));

  // R10: starting a busy cycle drops the latch and raises progress
  a_r10_busy_drops_wel: assert property (@(posedge clk) disable iff (rst)
    start_busy |=> (wip && !wel));

endmodule

// File: rtl/flash_pwrup_guard.sv
module flash_pwrup_guard
  import flash_pwr_pkg::*;
#(
  parameter int WR_DELAY    = 40,
  parameter int SEL_DELAY   = 12,
  parameter int BUSY_CYCLES = 8
) (
  input  logic       clk,
  input  logic       above_wi,
  input  logic       above_min,
  input  logic       instr_valid,
  input  logic [7:0] instr_code,
  output logic       core_rst,
  output logic       read_ok,
  output logic       write_ok,
  output logic       instr_accept,
  output logic       instr_ignore,
  output logic       wel,
  output logic       wip,
  output logic       deep_pd
);

  // Named internal events
  logic       wr_done, sel_done;
  logic       sel_clear;
  logic       permit;
  cmd_class_e cls;
  logic       take_wren, take_modify, take_dp, take_wake;

  assign core_rst  = ~above_wi;
  assign sel_clear = ~above_wi | ~above_min;

  power_delay_timer #(.LIMIT(WR_DELAY)) u_wr_timer (
    .clk   (clk),
    .clear (core_rst),
    .done  (wr_done)
  );

  power_delay_timer #(.LIMIT(SEL_DELAY)) u_sel_timer (
    .clk   (clk),
    .clear (sel_clear),
    .done  (sel_done)
  );

  assign read_ok  = above_wi & above_min & sel_done;
  assign write_ok = read_ok & wr_done;

  assign cls = classify(instr_code);

  always_comb begin
    if (deep_pd)               permit = read_ok & (instr_code == OP_WAKE);
    else if (cls == CLS_WRITE) permit = write_ok;
    else                       permit = read_ok;
  end

  assign instr_accept = instr_valid & permit;
  assign instr_ignore = instr_valid & ~permit;

  assign take_wren   = instr_accept & (instr_code == OP_WREN);
  assign take_modify = instr_accept & is_modify(instr_code) & wel & ~wip;
  assign take_dp     = instr_accept & (instr_code == OP_DPD);
  assign take_wake   = instr_accept & (instr_code == OP_WAKE) & deep_pd;

  flash_status_regs #(.BUSY_CYCLES(BUSY_CYCLES)) u_status (
    .clk        (clk),
    .rst        (core_rst),
    .set_wel    (take_wren),
    .start_busy (take_modify),
    .enter_dp   (take_dp),
    .leave_dp   (take_wake),
    .wel        (wel),
    .wip        (wip),
    .dpd        (deep_pd)
  );

  // R9: the latch only rises after an enable-write strobe
  a_r9_wel_from_wren: assert property (@(posedge clk) disable iff (core_rst)
    $rose(wel) |-> $past(instr_valid && instr_code == OP_WREN));

  // R5: a dropped strobe leaves the latch and power state alone
  a_r5_ignore_no_effect: assert property (@(posedge clk) disable iff (core_rst)
    instr_ignore |=> ($stable(wel) && $stable(deep_pd)));

  // R10: a busy cycle only begins while the latch is set
  a_r10_wip_needs_wel: assert property (@(posedge clk) disable iff (core_rst)
    $rose(wip) |-> $past(wel));

  // R3: read permission only appears with the rail at operating level
  a_r3_read_after_min: assert property (@(posedge clk) disable iff (core_rst)
    $rose(read_ok) |-> $past(above_min));

  // R1: nothing is accepted while the core is held in reset
  a_r1_reset_blocks: assert property (@(posedge clk)
    core_rst |-> !instr_accept);

endmodule

// File: tb/test_flash_pwrup_guard.sv
module test_flash_pwrup_guard;
  localparam int WR_DELAY    = 40;
  localparam int SEL_DELAY   = 12;
  localparam int BUSY_CYCLES = 8;

  logic       clk = 1'b0;
  logic       above_wi = 1'b0;
  logic       above_min = 1'b0;
  logic       instr_valid = 1'b0;
  logic [7:0] instr_code = 8'h00;
  logic       core_rst, read_ok, write_ok, instr_accept, instr_ignore;
  logic       wel, wip, deep_pd;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  flash_pwrup_guard #(
    .WR_DELAY(WR_DELAY), .SEL_DELAY(SEL_DELAY), .BUSY_CYCLES(BUSY_CYCLES)
  ) i_flash_pwrup_guard (
    .clk(clk), .above_wi(above_wi), .above_min(above_min),
    .instr_valid(instr_valid), .instr_code(instr_code),
    .core_rst(core_rst), .read_ok(read_ok), .write_ok(write_ok),
    .instr_accept(instr_accept), .instr_ignore(instr_ignore),
    .wel(wel), .wip(wip), .deep_pd(deep_pd)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Combinational probe: no clock edge is crossed
  task automatic probe(input string req, input logic [7:0] code, input int exp_acc);
    instr_code = code; instr_valid = 1'b1;
    #1;
    chk(req, $sformatf("accept %02h", code), int'(instr_accept), exp_acc);
    chk(req, $sformatf("ignore %02h", code), int'(instr_ignore), 1 - exp_acc);
    instr_valid = 1'b0;
  endtask

  // Strobe held across one rising edge
  task automatic issue(input string req, input logic [7:0] code, input int exp_acc);
    instr_code = code; instr_valid = 1'b1;
    #1;
    chk(req, $sformatf("issue accept %02h", code), int'(instr_accept), exp_acc);
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
    chk(req, "ignore lasts one cycle", int'(instr_ignore), 0);
  endtask

  task automatic t_reset();
    above_wi = 1'b0; above_min = 1'b0;
    tick(3);
    chk("R1", "core_rst", int'(core_rst), 1);
    chk("R1", "read_ok", int'(read_ok), 0);
    chk("R1", "write_ok", int'(write_ok), 0);
    probe("R1", 8'h03, 0);
    probe("R1", 8'h06, 0);
    chk("R6", "wel", int'(wel), 0);
    chk("R6", "wip", int'(wip), 0);
    chk("R6", "deep_pd", int'(deep_pd), 0);
  endtask

  task automatic t_powerup();
    above_wi = 1'b1; above_min = 1'b1;
    tick(SEL_DELAY - 1);
    chk("R3", "read_ok one edge early", int'(read_ok), 0);
    probe("R3", 8'h03, 0);
    tick(1);
    chk("R3", "read_ok at limit", int'(read_ok), 1);
    probe("R3", 8'h0B, 1);
    probe("R3", 8'h03, 1);
    probe("R2", 8'h06, 0);
    probe("R2", 8'hD8, 0);
    issue("R5", 8'h06, 0);
    chk("R5", "wel after ignored enable", int'(wel), 0);
    tick(WR_DELAY - SEL_DELAY - 2);
    chk("R2", "write_ok one edge early", int'(write_ok), 0);
    tick(1);
    chk("R2", "write_ok at limit", int'(write_ok), 1);
    probe("R2", 8'h06, 1);
    probe("R2", 8'h02, 1);
    probe("R2", 8'hD8, 1);
    probe("R2", 8'hC7, 1);
    probe("R2", 8'h01, 1);
    tick(5);
    chk("R2", "write_ok saturated", int'(write_ok), 1);
  endtask

  task automatic t_latch_busy();
    issue("R10", 8'h02, 1);
    chk("R10", "wip without latch", int'(wip), 0);
    issue("R9", 8'h06, 1);
    chk("R9", "wel set", int'(wel), 1);
    issue("R10", 8'hD8, 1);
    chk("R10", "wip raised", int'(wip), 1);
    chk("R10", "wel cleared", int'(wel), 0);
    tick(BUSY_CYCLES - 1);
    chk("R10", "wip last busy cycle", int'(wip), 1);
    tick(1);
    chk("R10", "wip done", int'(wip), 0);
  endtask

  task automatic t_min_drop();
    above_min = 1'b0;
    #1;
    chk("R8", "read_ok drops", int'(read_ok), 0);
    chk("R8", "write_ok drops", int'(write_ok), 0);
    probe("R8", 8'h03, 0);
    tick(4);
    above_min = 1'b1;
    tick(SEL_DELAY - 1);
    chk("R8", "read_ok before restart ends", int'(read_ok), 0);
    tick(1);
    chk("R8", "read_ok back", int'(read_ok), 1);
    chk("R4", "write_ok back with read", int'(write_ok), 1);
  endtask

  task automatic t_brownout();
    issue("R9", 8'h06, 1);
    chk("R9", "wel before brown-out", int'(wel), 1);
    above_wi = 1'b0; above_min = 1'b0;
    #1;
    chk("R7", "core_rst immediate", int'(core_rst), 1);
    chk("R7", "read_ok immediate", int'(read_ok), 0);
    probe("R7", 8'h03, 0);
    tick(2);
    above_wi = 1'b1;
    chk("R6", "wel after reset", int'(wel), 0);
    tick(WR_DELAY + 3);
    chk("R4", "write_ok waits for min", int'(write_ok), 0);
    probe("R4", 8'h06, 0);
    above_min = 1'b1;
    tick(SEL_DELAY - 1);
    chk("R4", "write_ok before select ends", int'(write_ok), 0);
    tick(1);
    chk("R4", "write_ok after later delay", int'(write_ok), 1);
    chk("R7", "read_ok after restart", int'(read_ok), 1);
  endtask

  task automatic t_short_brownout();
    above_wi = 1'b0;
    tick(1);
    above_wi = 1'b1;
    tick(WR_DELAY - 1);
    chk("R7", "write timer restarted", int'(write_ok), 0);
    tick(1);
    chk("R7", "write timer expires again", int'(write_ok), 1);
  endtask

  task automatic t_deep_pd();
    issue("R11", 8'hB9, 1);
    chk("R11", "deep_pd set", int'(deep_pd), 1);
    probe("R11", 8'h03, 0);
    issue("R11", 8'h06, 0);
    chk("R5", "wel unchanged in deep pd", int'(wel), 0);
    chk("R5", "deep_pd unchanged", int'(deep_pd), 1);
    issue("R11", 8'hAB, 1);
    chk("R11", "deep_pd cleared", int'(deep_pd), 0);
    probe("R11", 8'h03, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_powerup();
    t_latch_busy();
    t_min_drop();
    t_brownout();
    t_short_brownout();
    t_deep_pd();
    finish_run();
  end

endmodule